// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block decides, for an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback), where each of the two ALU operands of the instruction in execute should come from. It compares the execute-stage source register numbers against the destinations of the two older instructions still in flight. It then picks one of four inputs for each operand mux: the register-file value, the ALU result held at the end of execute, the ALU result held at the end of memory, or the load data held at the end of memory. Registers are read in decode and written in writeback, so only read-after-write dependences need handling. The register file makes a writeback-stage write visible to a same-cycle decode read, so no source older than writeback is needed.

The block also finds the one dependence that bypassing cannot cover. This is a load in execute whose destination is read by the instruction in decode. When that happens, it holds the program counter and the fetch/decode register for one cycle and clears the control fields entering execute, so exactly one bubble is inserted. A store that needs a just-loaded value only as its write data does not stall. Instead, the value is forwarded from the writeback-stage load data into the memory-stage store data. Register 0 always reads zero and never causes bypassing or stalling. The unit is purely combinational.

Top module: `hzd_unit`

## Requirements
- R1: When no enabled, nonzero destination in the memory or writeback stage matches an execute-stage source, that operand's select is 0 (register file). Select codes: 0 register file, 1 memory-stage ALU result, 2 writeback-stage ALU result, 3 writeback-stage load data.
- R2: When the memory-stage instruction writes a nonzero register equal to the source and is not a load, the select is 1, whatever the writeback stage holds.
- R3: When only the writeback stage matches, the select is 2 if that instruction is not a load and 3 if it is a load.
- R4: A source, destination or store-data register number of 0 never produces a nonzero select, a stall or a store-data forward.
- R5: A load in execute with write enable and a nonzero destination, read by a used decode-stage source, raises both `hold_front` and `flush_idex` in the same cycle. Any other case, including a non-load producer in execute or a matching but unused source, leaves both low.
- R6: A store in decode whose second source (its write data) alone matches the execute-stage load does not stall. A match on its first source (its address base) does stall.
- R7: `store_fwd` is 1 exactly when a memory-stage store's nonzero data register equals the destination of a writeback-stage load with write enable.
- R8: When the memory-stage instruction matching a source is a load, the select is 0, even if the writeback stage also matches.
- R9: A stage with its write enable low never matches, for bypass selects, stalls or `store_fwd`.
- R10: The two operand selects are computed independently, each from its own source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | Decode-stage first source register |
| id_rs2 | input | AW | Decode-stage second source register |
| id_use1 | input | 1 | Decode-stage instruction reads its first source |
| id_use2 | input | 1 | Decode-stage instruction reads its second source |
| id_store | input | 1 | Decode-stage instruction is a store (second source is write data) |
| ex_rs1 | input | AW | Execute-stage first source register |
| ex_rs2 | input | AW | Execute-stage second source register |
| ex_rd | input | AW | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_rs2 | input | AW | Memory-stage store data register |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | AW | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_load | input | 1 | Writeback-stage instruction is a load |
| sel_a | output | 2 | First ALU operand source select |
| sel_b | output | 2 | Second ALU operand source select |
| store_fwd | output | 1 | Replace memory-stage store data with writeback load data |
| hold_front | output | 1 | Hold program counter and fetch/decode register |
| flush_idex | output | 1 | Clear control fields entering execute (bubble) |

## Verification
The bypass selects are swept over every source and destination number of a three-bit register space, with every combination of write-enable and load flags in both older stages. This separates register-0 suppression, younger-stage priority, the load-in-memory block and the choice between ALU and load data. The two operands carry different sources in each step, so that one cannot follow the other. The interlock is swept over all decode sources, the execute destination, both use flags, the store flag and both execute flags, which separates address-base from write-data dependences of stores. The store-data path is swept over its data register, the writeback destination and all three flags.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_MEM_ALU = 2'd1,
    SRC_WB_ALU  = 2'd2,
    SRC_WB_LOAD = 2'd3
  } opnd_src_e;

  localparam int unsigned NUM_OPERANDS = 2;
endpackage

// File: rtl/hzd_opnd_sel.sv
module hzd_opnd_sel
  import hzd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          wb_load,
  output opnd_src_e     sel
);
  logic src_live;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_live = (src != '0);
    mem_hit  = src_live && mem_wen && (mem_rd == src);
    wb_hit   = src_live && wb_wen && (wb_rd == src);
  end

  // Younger stage first; a load still in memory has no data to give.
  always_comb begin
    sel = SRC_REGFILE;
    if (mem_hit) begin
      sel = mem_load ? SRC_REGFILE : SRC_MEM_ALU;
    end else if (wb_hit) begin
      sel = wb_load ? SRC_WB_LOAD : SRC_WB_ALU;
    end
  end

  always_comb begin
    if (!$isunknown({src, mem_rd, mem_wen, mem_load, wb_rd, wb_wen, wb_load})) begin
      AST_ZERO_SRC_REGFILE: assert ((src != '0) || (sel == SRC_REGFILE)) else $error("reg0 bypassed"); // R4
      AST_YOUNGER_ALU_WINS: assert (!(mem_wen && !mem_load && src != '0 && mem_rd == src) || (sel == SRC_MEM_ALU)) else $error("priority"); // R2
      AST_LOAD_DATA_FROM_WB: assert ((sel != SRC_WB_LOAD) || (wb_load && wb_wen)) else $error("load data source"); // R3
      AST_MEM_LOAD_BLOCKS: assert (!(mem_wen && mem_load && src != '0 && mem_rd == src) || (sel == SRC_REGFILE)) else $error("mem load"); // R8
    end
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  output logic          load_use
);
  logic producer;
  logic need1;
  logic need2;

  always_comb begin
    producer = ex_load && ex_wen && (ex_rd != '0);
    need1    = id_use1 && (id_rs1 == ex_rd);
    // store write data is picked up later in the memory stage
    need2    = id_use2 && !id_store && (id_rs2 == ex_rd);
    load_use = producer && (need1 || need2);
  end

  always_comb begin
    if (!$isunknown({id_rs1, id_rs2, id_use1, id_use2, id_store, ex_rd, ex_wen, ex_load})) begin
      AST_STALL_NEEDS_LOAD: assert (!load_use || (ex_load && ex_wen && ex_rd != '0)) else $error("stall w/o load"); // R5
      AST_STORE_DATA_FREE: assert (!(id_store && !(id_use1 && id_rs1 == ex_rd)) || !load_use) else $error("store data stall"); // R6
    end
  end
endmodule

// File: rtl/hzd_store_fwd.sv
module hzd_store_fwd #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] mem_rs2,
  input  logic          mem_store,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          wb_load,
  output logic          store_fwd
);
  always_comb begin
    store_fwd = mem_store && (mem_rs2 != '0) && wb_wen && wb_load && (wb_rd == mem_rs2);
  end

  always_comb begin
    if (!$isunknown({mem_rs2, mem_store, wb_rd, wb_wen, wb_load})) begin
      AST_STFWD_FROM_LOAD: assert (!store_fwd || (wb_load && wb_wen && mem_store)) else $error("store fwd"); // R7
    end
  end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_store,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] mem_rs2,
  input  logic          mem_store,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          wb_load,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          store_fwd,
  output logic          hold_front,
  output logic          flush_idex
);
  logic [AW-1:0] ex_src [NUM_OPERANDS];
  opnd_src_e     ex_sel [NUM_OPERANDS];
  logic          load_use;

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  // R10: one independent selector per ALU operand
  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
    hzd_opnd_sel #(.AW(AW)) i_sel (
      .src      (ex_src[g]),
      .mem_rd   (mem_rd),
      .mem_wen  (mem_wen),
      .mem_load (mem_load),
      .wb_rd    (wb_rd),
      .wb_wen   (wb_wen),
      .wb_load  (wb_load),
      .sel      (ex_sel[g])
    );
  end

  hzd_load_use #(.AW(AW)) i_load_use (
    .id_rs1   (id_rs1),
    .id_rs2   (id_rs2),
    .id_use1  (id_use1),
    .id_use2  (id_use2),
    .id_store (id_store),
    .ex_rd    (ex_rd),
    .ex_wen   (ex_wen),
    .ex_load  (ex_load),
    .load_use (load_use)
  );

  hzd_store_fwd #(.AW(AW)) i_store_fwd (
    .mem_rs2   (mem_rs2),
    .mem_store (mem_store),
    .wb_rd     (wb_rd),
    .wb_wen    (wb_wen),
    .wb_load   (wb_load),
    .store_fwd (store_fwd)
  );

  always_comb begin
    sel_a      = ex_sel[0];
    sel_b      = ex_sel[1];
    hold_front = load_use;
    flush_idex = load_use;
  end

  always_comb begin
    if (!$isunknown({ex_rs1, ex_rs2, mem_rd, mem_wen, wb_rd, wb_wen})) begin
      AST_IDLE_NO_BYPASS: assert ((mem_wen || wb_wen) || (sel_a == 2'd0 && sel_b == 2'd0)) else $error("bypass w/o writer"); // R9
    end
  end
endmodule

// File: tb/test_hzd_unit.sv
module test_hzd_unit;
  localparam int  CLK_PERIOD = 10;
  localparam int  AW         = 3;
  localparam int  NREG       = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_use1, id_use2, id_store, ex_wen, ex_load, mem_wen, mem_load, mem_store, wb_wen, wb_load;
  logic [1:0] sel_a, sel_b;
  logic store_fwd, hold_front, flush_idex;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  hzd_unit #(.AW(AW)) i_hzd_unit (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2), .id_store(id_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load), .mem_rs2(mem_rs2), .mem_store(mem_store),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_load(wb_load),
    .sel_a(sel_a), .sel_b(sel_b), .store_fwd(store_fwd), .hold_front(hold_front), .flush_idex(flush_idex)
  );

  function automatic logic [1:0] exp_sel(int src, int mrd, bit mw, bit ml, int wrd, bit ww, bit wl);
    if (src != 0 && mw && mrd == src) return ml ? 2'd0 : 2'd1;
    if (src != 0 && ww && wrd == src) return wl ? 2'd3 : 2'd2;
    return 2'd0;
  endfunction

  function automatic string sel_tag(int src, int mrd, bit mw, bit ml, int wrd, bit ww);
    if (src == 0)                           return "R4";
    if (mw && mrd == src && ml)             return "R8";
    if (mw && mrd == src)                   return "R2";
    if (ww && wrd == src)                   return "R3";
    if (mrd == src || wrd == src)           return "R9";
    return "R1";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
    {id_use1, id_use2, id_store, ex_wen, ex_load, mem_wen, mem_load, mem_store, wb_wen, wb_load} = '0;
  endtask

  initial begin
    idle_inputs();
    @(negedge clk);
    // R1: quiet pipeline selects register file, no stall, no store forward
    check("R1", "sel_a idle", sel_a, 0);
    check("R1", "sel_b idle", sel_b, 0);
    check("R5", "hold idle", hold_front, 0);
    check("R5", "flush idle", flush_idex, 0);
    check("R7", "store_fwd idle", store_fwd, 0);

    // Bypass sweep; operand B uses a different source (R10)
    for (int s = 0; s < NREG; s++)
      for (int m = 0; m < NREG; m++)
        for (int w = 0; w < NREG; w++)
          for (int f = 0; f < 16; f++) begin
            int sb;
            sb = (s + 3) % NREG;
            @(posedge clk);
            ex_rs1 = AW'(s); ex_rs2 = AW'(sb);
            mem_rd = AW'(m); wb_rd = AW'(w);
            mem_wen = f[0]; mem_load = f[1]; wb_wen = f[2]; wb_load = f[3];
            @(negedge clk);
            check(sel_tag(s, m, f[0], f[1], w, f[2]), "sel_a", sel_a,
                  exp_sel(s, m, f[0], f[1], w, f[2], f[3]));
            check("R10", "sel_b", sel_b, exp_sel(sb, m, f[0], f[1], w, f[2], f[3]));
          end
    idle_inputs();

    // Load interlock sweep
    for (int r1 = 0; r1 < NREG; r1++)
      for (int r2 = 0; r2 < NREG; r2++)
        for (int d = 0; d < NREG; d++)
          for (int f = 0; f < 32; f++) begin
            bit st, hit1, hit2, exp;
            string tag;
            @(posedge clk);
            id_rs1 = AW'(r1); id_rs2 = AW'(r2); ex_rd = AW'(d);
            id_use1 = f[0]; id_use2 = f[1]; id_store = f[2]; ex_wen = f[3]; ex_load = f[4];
            st   = f[2];
            hit1 = f[0] && r1 == d;
            hit2 = f[1] && r2 == d;
            exp  = f[4] && f[3] && d != 0 && (hit1 || (hit2 && !st));
            if (d == 0)                 tag = "R4";
            else if (st && hit2)        tag = "R6";
            else if (!f[3])             tag = "R9";
            else                        tag = "R5";
            @(negedge clk);
            check(tag, "hold_front", hold_front, exp);
            check(tag, "flush_idex", flush_idex, exp);
          end
    idle_inputs();

    // Store data forward sweep
    for (int r = 0; r < NREG; r++)
      for (int w = 0; w < NREG; w++)
        for (int f = 0; f < 8; f++) begin
          bit exp;
          string tag;
          @(posedge clk);
          mem_rs2 = AW'(r); wb_rd = AW'(w);
          mem_store = f[0]; wb_wen = f[1]; wb_load = f[2];
          exp = f[0] && r != 0 && f[1] && f[2] && w == r;
          if (r == 0)       tag = "R4";
          else if (!f[1])   tag = "R9";
          else              tag = "R7";
          @(negedge clk);
          check(tag, "store_fwd", store_fwd, exp);
        end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule